// File: doc/BRIEF.md
# Nonvolatile Setting Commit Controller

This block sits beside an I2C slave in a dual-wiper, dual-gain trim device and decides when the live wiper and gain settings are copied into nonvolatile storage. The slave reports bus events as single-cycle pulses: a start, a repeated start, a stop, and a "register written" strobe carrying the register address and data byte. Every accepted write takes effect in the live registers at once. The copy into storage is launched only by a stop that closes a transaction which wrote something. A repeated start in its place leaves the change volatile.

While a copy is running, the block raises `busy_o`. The slave uses this signal to refuse its own address, so a master can poll for completion with acknowledge requests. The storage is modelled as an internal array with a valid flag per entry. The write time is a parameterised cycle count. On every power-up (release of `rst_n`) the block spends one cycle loading the stored values into the live registers. Entries that were never written take the reset defaults. A separate input `fab_rst_n` erases the modelled cells and marks them blank. `wp_i` high locks the settings.

Register map: wiper 0 at F8h, wiper 1 at F9h, both wipers at FAh, gain at FBh. The base address is a parameter.

Top module: `nvc_commit_ctrl`

## Requirements
- R1: An accepted register write (wp_i low, not busy) to F8h, F9h or FBh updates wiper 0, wiper 1 or the gain byte in the cycle after the strobe. A wiper keeps only the low 6 data bits (C2h becomes 02h). Writes to any other address, except FAh, change nothing.
- R2: A write to FAh loads the same 6-bit value into both wipers, and a following stop commits both entries in one store.
- R3: A stop that arrives while at least one register was written in the current transaction, with wp_i low, raises busy_o from the next cycle for exactly WR_CYCLES cycles. At the end of that window the written entries hold the live values in storage.
- R4: A repeated start after a write discards the pending store. The following stop raises no busy, and the live values keep their new contents.
- R5: A stop with no register write in its transaction, including a pure read, never raises busy_o.
- R6: With wp_i high, register writes are ignored and a stop launches no store. This holds even if a write was accepted earlier in that transaction, before wp_i rose.
- R7: While busy_o is high, register-written strobes change no live value.
- R8: A store writes only the entries written in its own transaction. Entries changed only by a cancelled (volatile) write keep their earlier stored value.
- R9: busy_o is high during reset and for the one cycle after release. In that cycle the live registers load the stored entries, and blank entries take 1Fh for each wiper and 11h for gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset; the stored cells survive it |
| fab_rst_n | input | 1 | Active-low erase of the modelled storage cells (all entries blank) |
| wp_i | input | 1 | Write lock: high ignores writes and blocks stores |
| ev_start_i | input | 1 | Start condition pulse from the slave |
| ev_rstart_i | input | 1 | Repeated start condition pulse |
| ev_stop_i | input | 1 | Stop condition pulse |
| ev_wr_i | input | 1 | Register-written strobe |
| ev_addr_i | input | ADDR_W | Register address of the write |
| ev_data_i | input | DATA_W | Data byte of the write |
| busy_o | output | 1 | High during recall and store; the slave refuses its address |
| wiper_o | output | NUM_WIPERS*WIPER_W | Live wiper positions, wiper 0 in the low bits |
| gain_o | output | DATA_W | Live gain byte |

## Verification
The hardest situations to reach from the ports are the ones where live and stored contents differ. Examples are a cancelled volatile write followed by a committed write to a different entry, or a strobe arriving in the middle of a store. Storage is visible only through a power-up recall. The stimulus therefore pulses `rst_n` after such sequences and compares the recalled values against a bench model of the cells. The random transactions mix lock changes, foreign addresses, cancellations and pure reads, with periodic power cycles. Directed cases inject a write strobe while busy and raise the lock between a write and its stop.

// File: rtl/nvc_pkg.sv
package nvc_pkg;
   typedef enum logic [1:0] {
      ST_RECALL = 2'd0,
      ST_IDLE   = 2'd1,
      ST_STORE  = 2'd2
   } nvc_state_e;
endpackage

// File: rtl/nvc_decode.sv
// Address decode: one select bit per storage entry (wipers then gain).
module nvc_decode #(
   parameter int ADDR_W     = 8,
   parameter int NUM_WIPERS = 2,
   parameter int REG_BASE   = 'hF8,
   localparam int NUM_ENT   = NUM_WIPERS + 1
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic [NUM_ENT-1:0] sel
);
   localparam logic [ADDR_W-1:0] ALL_ADDR  = ADDR_W'(REG_BASE + NUM_WIPERS);
   localparam logic [ADDR_W-1:0] GAIN_ADDR = ADDR_W'(REG_BASE + NUM_WIPERS + 1);

   for (genvar i = 0; i < NUM_WIPERS; i++) begin : g_wiper
      localparam logic [ADDR_W-1:0] OWN_ADDR = ADDR_W'(REG_BASE + i);
      assign sel[i] = (addr == OWN_ADDR) || (addr == ALL_ADDR);
   end
   assign sel[NUM_WIPERS] = (addr == GAIN_ADDR);
endmodule

// File: rtl/nvc_cells.sv
// Modelled nonvolatile array: survives rst_n, erased only by fab_rst_n.
module nvc_cells #(
   parameter int NUM_ENT = 3,
   parameter int DATA_W  = 8
) (
   input  logic                        clk,
   input  logic                        fab_rst_n,
   input  logic [NUM_ENT-1:0]          we,
   input  logic [NUM_ENT*DATA_W-1:0]   wdata,
   output logic [NUM_ENT*DATA_W-1:0]   rdata,
   output logic [NUM_ENT-1:0]          vld
);
   for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
      logic [DATA_W-1:0] cell_q;
      logic              vld_q;
      always_ff @(posedge clk or negedge fab_rst_n) begin
         if (!fab_rst_n) begin
            cell_q <= '0;
            vld_q  <= 1'b0;
         end else if (we[e]) begin
            cell_q <= wdata[e*DATA_W +: DATA_W];
            vld_q  <= 1'b1;
         end
      end
      assign rdata[e*DATA_W +: DATA_W] = cell_q;
      assign vld[e] = vld_q;
   end
endmodule

// File: rtl/nvc_timer.sv
// Store-time countdown; expired is high when the count has reached zero.
module nvc_timer #(
   parameter int CYCLES = 500000,
   localparam int CNT_W = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic tick,
   output logic expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (load)                   cnt_q <= CNT_W'(CYCLES - 1);
      else if (tick && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/nvc_commit_ctrl.sv
module nvc_commit_ctrl #(
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 8,
   parameter int WIPER_W       = 6,
   parameter int NUM_WIPERS    = 2,
   parameter int REG_BASE      = 'hF8,
   parameter int WIPER_DEFAULT = 'h1F,
   parameter int GAIN_DEFAULT  = 'h11,
   parameter int WR_CYCLES     = 500000
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           fab_rst_n,
   input  logic                           wp_i,
   input  logic                           ev_start_i,
   input  logic                           ev_rstart_i,
   input  logic                           ev_stop_i,
   input  logic                           ev_wr_i,
   input  logic [ADDR_W-1:0]              ev_addr_i,
   input  logic [DATA_W-1:0]              ev_data_i,
   output logic                           busy_o,
   output logic [NUM_WIPERS*WIPER_W-1:0]  wiper_o,
   output logic [DATA_W-1:0]              gain_o
);
   import nvc_pkg::*;

   localparam int NUM_ENT = NUM_WIPERS + 1;
   localparam logic [DATA_W-1:0] WMASK   = DATA_W'((1 << WIPER_W) - 1);
   localparam logic [DATA_W-1:0] W_DFLT  = DATA_W'(WIPER_DEFAULT) & WMASK;
   localparam logic [DATA_W-1:0] G_DFLT  = DATA_W'(GAIN_DEFAULT);

   // elaboration-time parameter checks
   if (WIPER_W < 1 || WIPER_W > DATA_W) begin : g_bad_wiper_w
      $error("WIPER_W must lie in 1..DATA_W");
   end
   if (WR_CYCLES < 1) begin : g_bad_cycles
      $error("WR_CYCLES must be at least 1");
   end
   if (NUM_WIPERS < 1) begin : g_bad_num
      $error("NUM_WIPERS must be at least 1");
   end
   if (REG_BASE + NUM_WIPERS + 1 >= (1 << ADDR_W)) begin : g_bad_map
      $error("register map does not fit ADDR_W");
   end

   nvc_state_e                        state_q;
   logic [NUM_ENT-1:0][DATA_W-1:0]    live_q;
   logic [NUM_ENT-1:0]                dirty_q;
   logic [NUM_ENT-1:0]                commit_q;
   logic [NUM_ENT-1:0]                sel;
   logic [NUM_ENT*DATA_W-1:0]         cell_rd;
   logic [NUM_ENT-1:0]                cell_vld;
   logic [NUM_ENT-1:0]                cell_we;
   logic                              wr_ok;
   logic                              launch;
   logic                              store_act;
   logic                              t_expired;
   logic                              txn_edge;

   nvc_decode #(
      .ADDR_W     (ADDR_W),
      .NUM_WIPERS (NUM_WIPERS),
      .REG_BASE   (REG_BASE)
   ) i_decode (
      .addr (ev_addr_i),
      .sel  (sel)
   );

   assign store_act = (state_q == ST_STORE);
   assign wr_ok     = ev_wr_i && !wp_i && (state_q == ST_IDLE);
   assign txn_edge  = ev_start_i || ev_rstart_i || ev_stop_i;
   assign launch    = (state_q == ST_IDLE) && ev_stop_i && (|dirty_q) && !wp_i;
   assign cell_we   = (store_act && t_expired) ? commit_q : '0;

   nvc_timer #(
      .CYCLES (WR_CYCLES)
   ) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (launch),
      .tick    (store_act),
      .expired (t_expired)
   );

   nvc_cells #(
      .NUM_ENT (NUM_ENT),
      .DATA_W  (DATA_W)
   ) i_cells (
      .clk       (clk),
      .fab_rst_n (fab_rst_n),
      .we        (cell_we),
      .wdata     (live_q),
      .rdata     (cell_rd),
      .vld       (cell_vld)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_RECALL;
         dirty_q  <= '0;
         commit_q <= '0;
         for (int e = 0; e < NUM_ENT; e++)
            live_q[e] <= (e < NUM_WIPERS) ? W_DFLT : G_DFLT;
      end else begin
         case (state_q)
            ST_RECALL: begin
               for (int e = 0; e < NUM_ENT; e++) begin
                  if (cell_vld[e])
                     live_q[e] <= cell_rd[e*DATA_W +: DATA_W];
                  else
                     live_q[e] <= (e < NUM_WIPERS) ? W_DFLT : G_DFLT;
               end
               state_q <= ST_IDLE;
            end
            ST_IDLE: begin
               if (wr_ok) begin
                  for (int e = 0; e < NUM_ENT; e++) begin
                     if (sel[e])
                        live_q[e] <= (e < NUM_WIPERS) ? (ev_data_i & WMASK) : ev_data_i;
                  end
               end
               if (txn_edge)   dirty_q <= '0;
               else if (wr_ok) dirty_q <= dirty_q | sel;
               if (launch) begin
                  commit_q <= dirty_q;
                  state_q  <= ST_STORE;
               end
            end
            ST_STORE: begin
               if (t_expired) begin
                  commit_q <= '0;
                  state_q  <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != ST_IDLE);

   for (genvar i = 0; i < NUM_WIPERS; i++) begin : g_wout
      assign wiper_o[i*WIPER_W +: WIPER_W] = live_q[i][WIPER_W-1:0];
   end
   assign gain_o = live_q[NUM_WIPERS];
endmodule

// File: rtl/nvc_commit_chk.sv
module nvc_commit_chk #(
   parameter int NUM_ENT   = 3,
   parameter int DATA_W    = 8,
   parameter int WR_CYCLES = 500000
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      wp_i,
   input logic                      ev_stop_i,
   input logic                      ev_rstart_i,
   input logic                      ev_wr_i,
   input logic                      busy_o,
   input logic                      store_act,
   input logic [NUM_ENT-1:0]        dirty_q,
   input logic [NUM_ENT*DATA_W-1:0] live_flat
);
   int unsigned run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         run_q <= 0;
      else if (store_act) run_q <= run_q + 1;
      else                run_q <= 0;
   end

   // R3: a stop closing a written transaction starts the store
   a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_stop_i && (|dirty_q) && !wp_i && !busy_o) |=> store_act);

   // R3: the store window lasts exactly WR_CYCLES cycles
   a_r3_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(store_act) |-> (run_q == WR_CYCLES));

   // R5: without a qualifying stop an idle controller stays idle
   a_r5_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !(ev_stop_i && (|dirty_q) && !wp_i)) |=> !busy_o);

   // R4: a repeated start drops the pending store
   a_r4_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rstart_i && !busy_o) |=> (dirty_q == '0));

   // R7: live settings are frozen during a store
   a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      store_act |=> $stable(live_flat));

   // R6: locked writes do not move the live settings
   a_r6_wp_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_i && ev_wr_i && !busy_o) |=> $stable(live_flat));
endmodule

bind nvc_commit_ctrl nvc_commit_chk #(
   .NUM_ENT   (NUM_ENT),
   .DATA_W    (DATA_W),
   .WR_CYCLES (WR_CYCLES)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wp_i        (wp_i),
   .ev_stop_i   (ev_stop_i),
   .ev_rstart_i (ev_rstart_i),
   .ev_wr_i     (ev_wr_i),
   .busy_o      (busy_o),
   .store_act   (store_act),
   .dirty_q     (dirty_q),
   .live_flat   (live_q)
);

// File: tb/test_nvc_commit_ctrl.sv
module test_nvc_commit_ctrl;
   localparam int WRC = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fab_rst_n = 1'b0;
   logic        wp = 1'b0;
   logic        ev_start = 1'b0, ev_rstart = 1'b0, ev_stop = 1'b0, ev_wr = 1'b0;
   logic [7:0]  ev_addr = 8'h00, ev_data = 8'h00;
   logic        busy_o;
   logic [11:0] wiper_o;
   logic [7:0]  gain_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [7:0] m_live [3];
   logic [7:0] m_cell [3];
   bit         m_vld  [3];
   bit [2:0]   m_dirty;

   always #10 clk = ~clk;

   nvc_commit_ctrl #(.WR_CYCLES(WRC)) i_nvc_commit_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .fab_rst_n   (fab_rst_n),
      .wp_i        (wp),
      .ev_start_i  (ev_start),
      .ev_rstart_i (ev_rstart),
      .ev_stop_i   (ev_stop),
      .ev_wr_i     (ev_wr),
      .ev_addr_i   (ev_addr),
      .ev_data_i   (ev_data),
      .busy_o      (busy_o),
      .wiper_o     (wiper_o),
      .gain_o      (gain_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit [2:0] sel_of(input logic [7:0] a);
      case (a)
         8'hF8:   return 3'b001;
         8'hF9:   return 3'b010;
         8'hFA:   return 3'b011;
         8'hFB:   return 3'b100;
         default: return 3'b000;
      endcase
   endfunction

   function automatic logic [7:0] dflt(input int e);
      return (e < 2) ? 8'h1F : 8'h11;
   endfunction

   task automatic check_live(input string req);
      chk({req, " wiper0"}, {26'd0, wiper_o[5:0]},  {24'd0, m_live[0]});
      chk({req, " wiper1"}, {26'd0, wiper_o[11:6]}, {24'd0, m_live[1]});
      chk({req, " gain"},   {24'd0, gain_o},        {24'd0, m_live[2]});
   endtask

   task automatic pulse(input bit s, input bit r, input bit p, input bit w,
                        input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      ev_start = s; ev_rstart = r; ev_stop = p; ev_wr = w; ev_addr = a; ev_data = d;
      @(negedge clk);
      ev_start = 0; ev_rstart = 0; ev_stop = 0; ev_wr = 0;
   endtask

   // register write with model update and immediate live check (R1)
   task automatic wr(input logic [7:0] a, input logic [7:0] d, input string req);
      bit [2:0] s;
      s = sel_of(a);
      pulse(0, 0, 0, 1, a, d);
      if (!wp) begin
         for (int e = 0; e < 3; e++)
            if (s[e]) m_live[e] = (e < 2) ? (d & 8'h3F) : d;
         m_dirty |= s;
      end
      check_live(req);
   endtask

   task automatic do_stop(input string req);
      bit launch;
      bit [2:0] snap;
      int n;
      launch = (m_dirty != 0) && !wp;
      snap = m_dirty;
      m_dirty = 0;
      pulse(0, 0, 1, 0, 8'h00, 8'h00);
      if (launch) begin
         n = 0;
         while (busy_o && n < WRC + 10) begin
            n++;
            @(negedge clk);
         end
         chk({req, " R3 busy length"}, n, WRC);
         for (int e = 0; e < 3; e++)
            if (snap[e]) begin m_cell[e] = m_live[e]; m_vld[e] = 1; end
      end else begin
         chk({req, " R5 no store"}, {31'd0, busy_o}, 0);
      end
      check_live(req);
   endtask

   task automatic do_rstart(input string req);
      m_dirty = 0;
      pulse(0, 1, 0, 0, 8'h00, 8'h00);
      chk({req, " R4 no busy after rstart"}, {31'd0, busy_o}, 0);
   endtask

   task automatic power_cycle(input string req);
      @(negedge clk) rst_n = 0;
      #1 chk({req, " R9 busy in reset"}, {31'd0, busy_o}, 1);
      @(negedge clk) rst_n = 1;
      chk({req, " R9 busy in recall"}, {31'd0, busy_o}, 1);
      @(negedge clk);
      chk({req, " R9 idle after recall"}, {31'd0, busy_o}, 0);
      for (int e = 0; e < 3; e++) m_live[e] = m_vld[e] ? m_cell[e] : dflt(e);
      m_dirty = 0;
      check_live({req, " R9 recall"});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int e = 0; e < 3; e++) begin m_cell[e] = 0; m_vld[e] = 0; m_live[e] = dflt(e); end
      m_dirty = 0;
      repeat (3) @(negedge clk);
      chk("R9 busy during reset", {31'd0, busy_o}, 1);
      check_live("R9 reset defaults");
      fab_rst_n = 1;
      power_cycle("blank");

      // R1 masking + R3 commit
      pulse(1, 0, 0, 0, 0, 0);
      wr(8'hF8, 8'hC2, "R1 masked wiper0");
      chk("R1 upper bits dropped", {26'd0, wiper_o[5:0]}, 32'h02);
      do_stop("R3 commit wiper0");

      // R2 both wipers, cancelled by repeated start (R4), then read + stop
      pulse(1, 0, 0, 0, 0, 0);
      wr(8'hFA, 8'h15, "R2 both wipers");
      do_rstart("R4 cancel");
      do_stop("R4 stop after cancel");
      chk("R4 volatile value kept", {26'd0, wiper_o[11:6]}, 32'h15);
      power_cycle("R4 after cancel");
      chk("R8 blank wiper1 recalls default", {26'd0, wiper_o[11:6]}, 32'h1F);

      // R8: volatile wiper1, then committed gain; wiper1 must not be stored
      pulse(1, 0, 0, 0, 0, 0);
      wr(8'hF9, 8'h30, "R8 volatile wiper1");
      do_rstart("R8 cancel");
      do_stop("R8 stop");
      pulse(1, 0, 0, 0, 0, 0);
      wr(8'hFB, 8'h22, "R8 gain write");
      do_stop("R8 commit gain");
      power_cycle("R8 recall");
      chk("R8 wiper1 not stored", {26'd0, wiper_o[11:6]}, 32'h1F);
      chk("R8 gain stored", {24'd0, gain_o}, 32'h22);

      // R2 commit of both wipers in one store
      pulse(1, 0, 0, 0, 0, 0);
      wr(8'hFA, 8'h2B, "R2 both wipers commit");
      do_stop("R2 single store");
      power_cycle("R2 recall");

      // R5 pure read and stop with no write; R1 foreign address
      pulse(1, 0, 0, 0, 0, 0);
      do_stop("R5 read only");
      pulse(1, 0, 0, 0, 0, 0);
      wr(8'h10, 8'h3C, "R1 foreign address ignored");
      do_stop("R5 foreign stop");

      // R6 lock
      wp = 1;
      pulse(1, 0, 0, 0, 0, 0);
      wr(8'hF8, 8'h07, "R6 locked write ignored");
      do_stop("R6 locked stop");
      wp = 0;
      pulse(1, 0, 0, 0, 0, 0);
      wr(8'hF9, 8'h09, "R6 write before lock");
      wp = 1;
      do_stop("R6 lock raised before stop");
      chk("R6 live kept", {26'd0, wiper_o[11:6]}, 32'h09);
      wp = 0;
      power_cycle("R6 recall");

      // R7 strobe during store is ignored
      pulse(1, 0, 0, 0, 0, 0);
      wr(8'hF8, 8'h11, "R7 setup");
      m_dirty = 0;
      m_cell[0] = 8'h11; m_vld[0] = 1;
      pulse(0, 0, 1, 0, 0, 0);
      chk("R7 busy after stop", {31'd0, busy_o}, 1);
      pulse(0, 0, 0, 1, 8'hF8, 8'h3A);
      chk("R7 still busy", {31'd0, busy_o}, 1);
      while (busy_o) @(negedge clk);
      check_live("R7 strobe while busy");
      power_cycle("R7 recall");

      // constrained random transactions
      for (int t = 0; t < 300; t++) begin
         int nw;
         wp = ($urandom % 6 == 0);
         pulse(1, 0, 0, 0, 0, 0);
         nw = $urandom % 3;
         for (int k = 0; k < nw; k++) begin
            int r;
            logic [7:0] a;
            r = $urandom % 6;
            a = (r < 4) ? 8'(8'hF8 + r) : 8'($urandom);
            wr(a, 8'($urandom), "R1 random write");
         end
         if ($urandom % 3 == 0) do_rstart("R4 random");
         do_stop("R3 random");
         if (t % 25 == 24) begin
            wp = 0;
            power_cycle("R9 random");
         end
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule